// File: doc/BRIEF.md
# AES Round-Key Expander with Borrowed S-Box Port

This block turns a 128-bit or 256-bit AES cipher key into the full set of round keys and holds them for the cipher datapaths. A one-cycle `init_i` pulse, given while the block is idle, captures the key and the key-length select. From the next cycle on, one 128-bit round key is produced and stored per clock until the last one is written. The stored keys are then served through a combinational read port addressed by round number.

The block has no substitution tables of its own. Each cycle of expansion sends one 32-bit word out on `sbox_word_o` to the four byte substitution boxes that belong to the cipher, and takes the substituted word back on `sbox_word_i` in the same cycle. While `sbox_own_o` is high those boxes belong to the expander, so no block may be enciphered until `ready_o` has returned high. The read port can be used at any time and is meant for block processing that follows a finished expansion.

Top module: `aes_rkey_expand`

## Requirements
- R1: After a synchronous active-low reset, `ready_o` is 1, `sbox_own_o` is 0 and every stored round key reads back as zero.
- R2: With `long_key_i`=0 at the accepted `init_i`, the cipher key is `key_i[255:128]`. Slot 0 holds that key and slots 1 to 10 hold the standard AES-128 round keys. `ready_o` is low for exactly 10 cycles after the accepting edge.
- R3: With `long_key_i`=1, slot 0 holds `key_i[255:128]` and slot 1 holds `key_i[127:0]`. Slots 2 to 14 hold the standard AES-256 round keys, and `ready_o` is low for exactly 13 cycles.
- R4: The round constant XORed into the top byte begins at 0x01. Each use doubles it in GF(2^8), with a reduction by 0x1b when bit 7 is shifted out.
- R5: For 256-bit keys, odd-numbered round keys (3, 5, ..., 13) substitute the last word of the previous round key with no byte rotation and no round constant.
- R6: An `init_i` that arrives while `ready_o` is low is ignored: the expansion in progress and its timing are unchanged.
- R7: `sbox_own_o` is high exactly while `ready_o` is low. In that time `sbox_word_o` carries the last word (bits 31:0) of the newest round key. That word is rotated left by one byte for every 128-bit round and for even 256-bit rounds, and sent as is for odd 256-bit rounds.
- R8: `rd_key_o` combinationally shows the slot chosen by `rd_idx_i`, where index 15 reads as zero. Slots that an expansion does not write keep their earlier contents.
- R9: Inside a 128-bit round key, word 0 occupies bits 127:96 and word 3 occupies bits 31:0. A round key's word n is the XOR of word n of the key one step back (one slot for 128-bit keys, two slots for 256-bit keys) with the new word n-1, or with the substituted word when n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Start-expansion strobe, taken only when idle |
| key_i | input | 256 | Cipher key; a 128-bit key sits in bits 255:128 |
| long_key_i | input | 1 | 1 selects a 256-bit key, 0 a 128-bit key |
| ready_o | output | 1 | All round keys of the last key are stored |
| sbox_own_o | output | 1 | Expander is using the shared substitution boxes |
| sbox_word_o | output | 32 | Word sent to the shared substitution boxes |
| sbox_word_i | input | 32 | Substituted word returned in the same cycle |
| rd_idx_i | input | 4 | Round number to read |
| rd_key_o | output | 128 | Round key stored at `rd_idx_i` |

## Verification
A wrong round counter or round-constant register spoils every later round key, and the word on `sbox_word_o` shows it within one cycle. A wrong rotate decision for 256-bit keys shows on that port in the first odd round. A wrong completion count shows as `ready_o` rising early or late, and the read port exposes any slot written with wrong data or at a wrong index as soon as that slot is addressed. For these reasons the bench compares the handshake, the substitution word and the addressed slot against a behavioural model on every clock, and it also checks published known answers for both key lengths.

// File: rtl/rkx_pkg.sv
// Package rkx_pkg: sizes and small helpers shared by the round-key expander.
// Assumes the standard AES word layout: word 0 in the top 32 bits of a round key.
package rkx_pkg;
    localparam int WORD_W   = 32;
    localparam int RK_W     = 128;
    localparam int KEY_W    = 256;
    localparam int NSLOT    = 15;
    localparam int IDX_W    = $clog2(NSLOT);
    localparam int NR_SHORT = 10;
    localparam int NR_LONG  = 14;

    // Multiply a field element by x in GF(2^8) modulo 0x11b.
    function automatic logic [7:0] xtime(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    // Cyclic left rotation of a word by one byte.
    function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
        return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
    endfunction
endpackage

// File: rtl/rkx_ctrl.sv
// Module rkx_ctrl: sequences one expansion. It accepts init only when idle,
// counts the round being produced, keeps the round constant and decides
// whether the current round rotates and adds the constant.
// Assumes the caller writes one round key per busy cycle.
module rkx_ctrl
    import rkx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             long_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             long_q_o,
    output logic [IDX_W-1:0] round_o,
    output logic             rot_rcon_o,
    output logic [7:0]       rcon_o
);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(NR_SHORT);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(NR_LONG);

    logic             ready_q;
    logic             long_q;
    logic [IDX_W-1:0] cnt_q;
    logic [7:0]       rcon_q;
    logic [IDX_W-1:0] last_round;
    logic             accept;

    // Decode acceptance, final round and the rotate/constant choice.
    always_comb begin
        accept     = init_i && ready_q;
        last_round = long_q ? LAST_LONG : LAST_SHORT;
        rot_rcon_o = !long_q || !cnt_q[0];
    end

    // Advance the round counter, round constant and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            long_q  <= 1'b0;
            cnt_q   <= '0;
            rcon_q  <= 8'h01;
        end else if (accept) begin
            ready_q <= 1'b0;
            long_q  <= long_i;
            cnt_q   <= long_i ? IDX_W'(2) : IDX_W'(1);
            rcon_q  <= 8'h01;
        end else if (!ready_q) begin
            if (rot_rcon_o) begin
                rcon_q <= xtime(rcon_q);
            end
            if (cnt_q == last_round) begin
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign load_o   = accept;
    assign busy_o   = !ready_q;
    assign long_q_o = long_q;
    assign round_o  = cnt_q;
    assign rcon_o   = rcon_q;

    // R2/R3: expansion ends right after the final round of its key length.
    a_r2_done_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> ($past(cnt_q) == ($past(long_q) ? LAST_LONG : LAST_SHORT)));

    // R6: once busy, every cycle advances one round or finishes, whatever init does.
    a_r6_busy_progress: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_q |=> (ready_q || (cnt_q == IDX_W'($past(cnt_q) + 1'b1))));

    // R4: the round constant stays on the doubling chain that starts at 0x01.
    a_r4_rcon_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rcon_q inside {8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80,
                       8'h1b, 8'h36, 8'h6c});
endmodule

// File: rtl/rkx_step.sv
// Module rkx_step: combinational step that builds the next round key.
// It forms the word sent to the shared S-boxes and then chains the four
// XORs with the older key. Assumes the substituted word returns in the same cycle.
module rkx_step
    import rkx_pkg::*;
(
    input  logic [RK_W-1:0]   base_i,
    input  logic [RK_W-1:0]   newest_i,
    input  logic              rot_rcon_i,
    input  logic [7:0]        rcon_i,
    output logic [WORD_W-1:0] sbox_word_o,
    input  logic [WORD_W-1:0] sbox_word_i,
    output logic [RK_W-1:0]   next_o
);
    localparam int NWORD = RK_W / WORD_W;

    logic [WORD_W-1:0] tail;
    logic [WORD_W-1:0] mix;
    logic [WORD_W-1:0] chain [NWORD+1];

    // Select the word to substitute and fold in the round constant.
    always_comb begin
        tail        = newest_i[WORD_W-1:0];
        sbox_word_o = rot_rcon_i ? rot_word(tail) : tail;
        mix         = sbox_word_i ^ (rot_rcon_i ? {rcon_i, 24'h0} : '0);
    end

    assign chain[0] = mix;

    // Each new word is the older key's word XOR the previous new word.
    for (genvar g = 0; g < NWORD; g++) begin : g_word
        assign chain[g+1] = base_i[RK_W-1-g*WORD_W -: WORD_W] ^ chain[g];
        assign next_o[RK_W-1-g*WORD_W -: WORD_W] = chain[g+1];
    end
endmodule

// File: rtl/rkx_store.sv
// Module rkx_store: round-key slots, a load path for the raw key and one
// write port for computed keys, with a combinational read by round number.
// Assumes load and write never coincide; out-of-range reads return zero.
module rkx_store
    import rkx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             load_long_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [RK_W-1:0]  wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [RK_W-1:0]  rdata_o
);
    localparam logic [IDX_W-1:0] TOP_SLOT = IDX_W'(NSLOT - 1);

    logic [RK_W-1:0] slot_q [NSLOT];

    // Write the raw key halves on load, or one computed round key per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                slot_q[i] <= '0;
            end
        end else if (load_i) begin
            slot_q[0] <= key_i[KEY_W-1 -: RK_W];
            if (load_long_i) begin
                slot_q[1] <= key_i[RK_W-1:0];
            end
        end else if (we_i && (widx_i <= TOP_SLOT)) begin
            slot_q[widx_i] <= wdata_i;
        end
    end

    // Serve the addressed slot, zero past the last one.
    always_comb begin
        rdata_o = (ridx_i <= TOP_SLOT) ? slot_q[ridx_i] : '0;
    end

    // R8: computed keys only target existing slots.
    a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (widx_i <= TOP_SLOT));
endmodule

// File: rtl/aes_rkey_expand.sv
// Module aes_rkey_expand: AES-128/256 round-key expansion, one round key per
// cycle, using the cipher's four S-boxes through a word port.
// Assumes no block is processed while sbox_own_o is high.
module aes_rkey_expand
    import rkx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              long_key_i,
    output logic              ready_o,
    output logic              sbox_own_o,
    output logic [WORD_W-1:0] sbox_word_o,
    input  logic [WORD_W-1:0] sbox_word_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [RK_W-1:0]   rd_key_o
);
    logic             load;
    logic             busy;
    logic             long_q;
    logic [IDX_W-1:0] round;
    logic             rot_rcon;
    logic [7:0]       rcon;
    logic [RK_W-1:0]  older_q;
    logic [RK_W-1:0]  newest_q;
    logic [RK_W-1:0]  next_rk;

    rkx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .long_i     (long_key_i),
        .load_o     (load),
        .busy_o     (busy),
        .long_q_o   (long_q),
        .round_o    (round),
        .rot_rcon_o (rot_rcon),
        .rcon_o     (rcon)
    );

    rkx_step u_step (
        .base_i      (long_q ? older_q : newest_q),
        .newest_i    (newest_q),
        .rot_rcon_i  (rot_rcon),
        .rcon_i      (rcon),
        .sbox_word_o (sbox_word_o),
        .sbox_word_i (sbox_word_i),
        .next_o      (next_rk)
    );

    rkx_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_long_i (long_key_i),
        .key_i       (key_i),
        .we_i        (busy),
        .widx_i      (round),
        .wdata_i     (next_rk),
        .ridx_i      (rd_idx_i),
        .rdata_o     (rd_key_o)
    );

    // Keep the two most recent round keys so the step never reads the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q  <= '0;
            newest_q <= '0;
        end else if (load) begin
            older_q  <= key_i[KEY_W-1 -: RK_W];
            newest_q <= long_key_i ? key_i[RK_W-1:0] : key_i[KEY_W-1 -: RK_W];
        end else if (busy) begin
            older_q  <= newest_q;
            newest_q <= next_rk;
        end
    end

    assign ready_o    = !busy;
    assign sbox_own_o = busy;

    // R7: the S-box word keeps a stable value while the expander is idle.
    a_r7_idle_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(load)) |-> $stable(sbox_word_o));
endmodule

// File: tb/sim_aes_rkey_expand.sv
module sim_aes_rkey_expand;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0;
    logic [255:0] key_i = '0;
    logic         long_key_i = 1'b0;
    logic         ready_o, sbox_own_o;
    logic [31:0]  sbox_word_o, sbox_word_i;
    logic [3:0]   rd_idx_i = '0;
    logic [127:0] rd_key_o;

    int n_chk = 0;
    int n_err = 0;
    bit run = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    aes_rkey_expand u0 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .key_i(key_i),
        .long_key_i(long_key_i), .ready_o(ready_o), .sbox_own_o(sbox_own_o),
        .sbox_word_o(sbox_word_o), .sbox_word_i(sbox_word_i),
        .rd_idx_i(rd_idx_i), .rd_key_o(rd_key_o)
    );

    // Behavioural S-box: field inverse by exponentiation, then the affine map.
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p, x;
        p = 8'h00; x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [7:0] sbyte(input logic [7:0] a);
        logic [7:0] r, s;
        r = 8'h01;
        if (a == 8'h00) r = 8'h00;
        else for (int i = 0; i < 254; i++) r = gmul(r, a);
        s = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
        return s;
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sbyte(w[31:24]), sbyte(w[23:16]), sbyte(w[15:8]), sbyte(w[7:0])};
    endfunction

    assign sbox_word_i = subw(sbox_word_o);

    // Textbook word-array expansion into round keys.
    task automatic expand(input logic [255:0] k, input logic lng, output logic [127:0] rk [15]);
        logic [31:0] w [60];
        logic [31:0] t;
        logic [7:0]  rc;
        int nk, nw;
        nk = lng ? 8 : 4;
        nw = lng ? 60 : 44;
        rc = 8'h01;
        for (int i = 0; i < nk; i++) w[i] = k[255-32*i -: 32];
        for (int i = nk; i < nw; i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
            end else if (nk == 8 && i % 8 == 4) begin
                t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r < 15; r++)
            rk[r] = (4*r+3 < nw) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : 128'h0;
    endtask

    // Cycle model of the store and handshake.
    logic [127:0] m_exp [15];
    logic [127:0] m_mem [15];
    logic m_ready, m_long;
    int   m_next;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready <= 1'b1;
            m_long  <= 1'b0;
            m_next  <= 0;
            for (int r = 0; r < 15; r++) m_mem[r] <= '0;
        end else if (m_ready && init_i) begin
            expand(key_i, long_key_i, m_exp);
            m_mem[0] <= m_exp[0];
            if (long_key_i) m_mem[1] <= m_exp[1];
            m_long  <= long_key_i;
            m_next  <= long_key_i ? 2 : 1;
            m_ready <= 1'b0;
        end else if (!m_ready) begin
            m_mem[m_next] <= m_exp[m_next];
            if (m_next == (m_long ? 14 : 10)) m_ready <= 1'b1;
            m_next <= m_next + 1;
        end
    end

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        logic [31:0] prev;
        logic        rot;
        #1;
        if (rst_n && run) begin
            chk("R2/R3 ready", {127'h0, ready_o}, {127'h0, m_ready});
            chk("R7 own", {127'h0, sbox_own_o}, {127'h0, !m_ready});
            chk("R8 read", rd_key_o, (rd_idx_i < 4'd15) ? m_mem[rd_idx_i] : 128'h0);
            if (!m_ready) begin
                prev = m_exp[m_next-1][31:0];
                rot  = !m_long || (m_next % 2 == 0);
                chk("R5/R7 sbox word", {96'h0, sbox_word_o},
                    {96'h0, rot ? {prev[23:0], prev[31:24]} : prev});
            end
        end
    end

    task automatic rd_chk(input string tag, input logic [3:0] idx, input logic [127:0] exp);
        @(negedge clk);
        rd_idx_i = idx;
        #1;
        chk(tag, rd_key_o, exp);
    endtask

    // Start an expansion and count the cycles ready_o stays low.
    task automatic run_key(input logic [255:0] k, input logic lng, output int n);
        @(negedge clk);
        init_i = 1'b1; key_i = k; long_key_i = lng;
        @(negedge clk);
        init_i = 1'b0;
        #1;
        n = 0;
        while (!ready_o) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog expired got 0 exp 1");
        summary();
    end

    initial begin
        logic [127:0] ref_a [15];
        logic [127:0] ref_b [15];
        logic [255:0] k128, k256;
        int n;
        k128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
        k256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;
        @(negedge clk); #1;
        chk("R1 ready after reset", {127'h0, ready_o}, 128'h1);
        chk("R1 own after reset", {127'h0, sbox_own_o}, 128'h0);
        rd_chk("R1 slot 0 zero", 4'd0, 128'h0);
        rd_chk("R1 slot 14 zero", 4'd14, 128'h0);

        // R2 R4 R9: known-answer 128-bit expansion (last round uses constant 0x36).
        run_key(k128, 1'b0, n);
        chk("R2 busy cycles 128", 128'(n), 128'd10);
        rd_chk("R2 slot 0 is key", 4'd0, k128[255:128]);
        rd_chk("R4 R9 round 10 known answer", 4'd10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        // R3 R5: known-answer 256-bit expansion.
        run_key(k256, 1'b1, n);
        chk("R3 busy cycles 256", 128'(n), 128'd13);
        rd_chk("R3 slot 1 is key low", 4'd1, k256[127:0]);
        rd_chk("R3 R5 round 14 known answer", 4'd14, 128'hfe4890d1e6188d0b046df344706c631e);

        // R8: a 128-bit run after a 256-bit run leaves slots 11..14 alone.
        expand(k256, 1'b1, ref_b);
        run_key({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 1'b0, n);
        rd_chk("R8 slot 12 kept", 4'd12, ref_b[12]);
        rd_chk("R8 index 15 reads zero", 4'd15, 128'h0);

        // R6: init during expansion is ignored.
        expand({128'hffeeddccbbaa99887766554433221100, 128'h0}, 1'b0, ref_a);
        @(negedge clk);
        init_i = 1'b1; key_i = {128'hffeeddccbbaa99887766554433221100, 128'h0}; long_key_i = 1'b0;
        @(negedge clk);
        init_i = 1'b0;
        repeat (2) @(negedge clk);
        init_i = 1'b1; key_i = {256{1'b1}}; long_key_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0; key_i = '0;
        #1;
        n = 3;
        while (!ready_o) begin n++; @(negedge clk); #1; end
        chk("R6 busy cycles unchanged", 128'(n), 128'd10);
        rd_chk("R6 round 10 from first key", 4'd10, ref_a[10]);

        // R2 R3: further key patterns, every slot against the reference.
        for (int p = 0; p < 4; p++) begin
            logic [255:0] kk;
            logic         lg;
            kk = (p == 0) ? 256'h0 : (p == 1) ? {256{1'b1}} :
                 (p == 2) ? {8{32'h80000001}} : {16{16'h5aa5}};
            lg = p[0];
            expand(kk, lg, ref_a);
            run_key(kk, lg, n);
            chk(lg ? "R3 busy cycles" : "R2 busy cycles", 128'(n), lg ? 128'd13 : 128'd10);
            for (int r = 0; r < (lg ? 15 : 11); r++) begin
                logic [3:0] ri;
                ri = 4'(r);
                rd_chk(lg ? "R3 slot" : "R2 slot", ri, ref_a[r]);
            end
        end

        repeat (3) @(negedge clk);
        summary();
    end
endmodule